// File: doc/BRIEF.md
# Vector-Length Scaled Address Adder

This block decodes one 32-bit instruction word and, when it matches, adds a signed multiple of the predicate-register size in bytes to a 64-bit base value. The predicate size comes from a runtime vector length: it is one sixty-fourth of the vector length in bits. The base is read from a 31-entry general register file, or from the stack pointer when the source index is 31. The sum is written back to a general register, or to the stack pointer when the destination index is 31.

A word is offered with a valid/ready handshake. It is accepted on a clock edge, and the result, the write enable and the undefined flag appear registered one cycle later. Words that do not match the encoding, and any word offered while the feature enable is low, raise the undefined flag and change no state. A load port presets any register or the stack pointer, and it takes priority over the instruction input.

Top module: `vl_scaled_adder`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0, and all 31 general registers and the stack pointer read as zero.
- R2: `out_valid` is 1 in exactly the cycle after an accepted word (`in_valid` and `in_ready` both 1 at a clock edge), whatever the operands and immediate are. `in_ready` equals the inverse of `load_en`. A word written back is visible to the word accepted in the next cycle.
- R3: A word matches only when bits 31..21 are 00000100011 and bits 15..11 are 01010. Source index is bits 20..16, immediate bits 10..5, destination index bits 4..0. A non-matching accepted word gives `out_undef`=1 and `out_wr_en`=0, and writes no register.
- R4: A word accepted while `feat_en` is 0 gives `out_undef`=1 and `out_wr_en`=0, and writes no register, even when it matches.
- R5: The 6-bit immediate is two's complement, covering -32 to +31.
- R6: The result is base + imm × (vl / 64). `vl` must be a multiple of 128 from 128 to 2048.
- R7: Source index 31 reads the stack pointer. Indices 0..30 read general registers.
- R8: Destination index 31 writes the stack pointer. Indices 0..30 write general registers. `out_wr_idx` reports the destination.
- R9: When `load_en` is 1, `load_data` is written at the clock edge to the register selected by `load_idx`, where 31 selects the stack pointer.
- R10: The sum is taken modulo 2^64 and wraps silently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Word can be accepted (low while loading) |
| instr | input | 32 | Instruction word |
| vl | input | 12 | Vector length in bits |
| feat_en | input | 1 | Feature enable |
| load_en | input | 1 | Preset register write |
| load_idx | input | 5 | Preset target (31 = stack pointer) |
| load_data | input | 64 | Preset value |
| out_valid | output | 1 | Result for the word accepted in the previous cycle |
| out_undef | output | 1 | That word was undefined |
| out_wr_en | output | 1 | That word wrote a register |
| out_wr_idx | output | 5 | Destination index written |
| out_result | output | 64 | Computed sum |

## Verification
The adder is driven with vector lengths whose scale is a power of two (2, 32) and with ones that are not (6). This separates a correct shift-and-add from a plain shift. Immediates at -32, -1, 0 and +31 expose a wrong sign extension. A base near 2^64 checks that the sum wraps. Index 31 is used on both the read and the write side, so that stack pointer selection can be told apart from general register 31. Dependent back-to-back words expose write-before-read ordering. Mismatched and feature-disabled words are each followed by a zero-immediate read of their destination, which shows at the result port that nothing was written.

// File: rtl/vlsa_pkg.sv
// Package: shared constants and the decoded-word type for the scaled adder.
// Assumes a 32-bit instruction word with 5-bit register indices.
package vlsa_pkg;
    localparam int IDX_W = 5;
    localparam int IMM_W = 6;
    localparam logic [10:0] OPC_HI = 11'b00000100011;
    localparam logic [4:0]  OPC_MID = 5'b01010;
    localparam logic [IDX_W-1:0] SP_IDX = 5'd31;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] src;
        logic [IDX_W-1:0] dst;
        logic [IMM_W-1:0] imm;
    } dec_t;
endpackage

// File: rtl/vlsa_decode.sv
// Decoder: splits the instruction word into fields and flags a match on the
// fixed opcode bits. Purely combinational; assumes nothing about validity.
module vlsa_decode
    import vlsa_pkg::*;
(
    input  logic [31:0] word,
    output dec_t        dec
);
    // Field extraction and fixed-bit comparison.
    always_comb begin
        dec.hit = (word[31:21] == OPC_HI) && (word[15:11] == OPC_MID);
        dec.src = word[20:16];
        dec.dst = word[4:0];
        dec.imm = word[10:5];
    end
endmodule

// File: rtl/vlsa_scale.sv
// Scaler: forms sign-extended imm * (vl / 64) with a shift-and-add network.
// Each set bit of the scale contributes one shifted copy of the immediate.
// Assumes vl is a multiple of 128 in 128..2048 (checked at the top).
module vlsa_scale #(
    parameter int XLEN  = 64,
    parameter int VL_W  = 12,
    parameter int IMM_W = 6
) (
    input  logic [IMM_W-1:0] imm,
    input  logic [VL_W-1:0]  vl,
    output logic [XLEN-1:0]  addend
);
    localparam int SC_W = VL_W - 6;

    logic [SC_W-1:0] scale;
    logic [XLEN-1:0] imm_x;
    logic [XLEN-1:0] part [SC_W];

    assign scale = vl[VL_W-1:6];
    assign imm_x = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};

    // One gated shifted partial product per scale bit.
    for (genvar k = 0; k < SC_W; k++) begin : g_part
        assign part[k] = scale[k] ? (imm_x << k) : '0;
    end

    // Sum of the partial products, modulo 2^XLEN.
    always_comb begin
        addend = '0;
        for (int k = 0; k < SC_W; k++) addend = addend + part[k];
    end
endmodule

// File: rtl/vlsa_regs.sv
// Register file: NREG general registers plus a stack pointer at index 31.
// One combinational read port, one write port; synchronous active-low reset
// clears everything to zero.
module vlsa_regs
    import vlsa_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NREG = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]  rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data
);
    logic [XLEN-1:0] gpr [NREG];
    logic [XLEN-1:0] sp_q;

    // One storage process per general register.
    for (genvar i = 0; i < NREG; i++) begin : g_gpr
        always_ff @(posedge clk) begin
            if (!rst_n) gpr[i] <= '0;
            else if (wr_en && wr_idx == IDX_W'(i)) gpr[i] <= wr_data;
        end
    end

    // Stack pointer storage, written only through index 31.
    always_ff @(posedge clk) begin
        if (!rst_n) sp_q <= '0;
        else if (wr_en && wr_idx == SP_IDX) sp_q <= wr_data;
    end

    // Read mux: stack pointer unless a general index matches.
    always_comb begin
        rd_data = sp_q;
        for (int i = 0; i < NREG; i++)
            if (rd_idx == IDX_W'(i)) rd_data = gpr[i];
    end

    AST_SP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == SP_IDX) |=> (sp_q == $past(wr_data))); // R8
    AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_idx != SP_IDX) |=> $stable(sp_q)); // R3
endmodule

// File: rtl/vl_scaled_adder.sv
// Top: accepts one instruction word per cycle, adds imm * (vl/64) to the
// selected base and writes the sum back. Results and status are registered,
// so out_valid follows acceptance by exactly one cycle. The load port has
// priority over the instruction input.
module vl_scaled_adder
    import vlsa_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int VL_W = 12,
    parameter int NREG = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [31:0]      instr,
    input  logic [VL_W-1:0]  vl,
    input  logic             feat_en,
    input  logic             load_en,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [XLEN-1:0]  load_data,
    output logic             out_valid,
    output logic             out_undef,
    output logic             out_wr_en,
    output logic [IDX_W-1:0] out_wr_idx,
    output logic [XLEN-1:0]  out_result
);
    dec_t            dec;
    logic            accept, undef, rf_we;
    logic [IDX_W-1:0] rf_widx;
    logic [XLEN-1:0] base, addend, sum, rf_wdata;

    vlsa_decode u_dec (.word(instr), .dec(dec));

    vlsa_scale #(.XLEN(XLEN), .VL_W(VL_W), .IMM_W(IMM_W)) u_scale (
        .imm(dec.imm), .vl(vl), .addend(addend));

    vlsa_regs #(.XLEN(XLEN), .NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .rd_idx(dec.src), .rd_data(base),
        .wr_en(rf_we), .wr_idx(rf_widx), .wr_data(rf_wdata));

    // Handshake and legality of the offered word.
    always_comb begin
        in_ready = !load_en;
        accept   = in_valid && in_ready;
        undef    = !(dec.hit && feat_en);
        sum      = base + addend;
    end

    // Register-file write select: load port first, then a legal word.
    always_comb begin
        rf_we    = load_en || (accept && !undef);
        rf_widx  = load_en ? load_idx : dec.dst;
        rf_wdata = load_en ? load_data : sum;
    end

    // Registered result and status for the accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_undef  <= 1'b0;
            out_wr_en  <= 1'b0;
            out_wr_idx <= '0;
            out_result <= '0;
        end else begin
            out_valid  <= accept;
            out_undef  <= accept && undef;
            out_wr_en  <= accept && !undef;
            out_wr_idx <= dec.dst;
            out_result <= undef ? '0 : sum;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !load_en) |=> out_valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && !load_en) |=> !out_valid); // R2
    AST_UNDEF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> (out_valid && !out_wr_en)); // R3
    AST_FEAT_OFF_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !load_en && !feat_en) |=> out_undef); // R4
    AST_VL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (vl[6:0] == 7'd0 && vl >= VL_W'(128) && vl <= VL_W'(2048))); // R6
endmodule

// File: tb/tb_vl_scaled_adder.sv
module tb_vl_scaled_adder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, feat_en = 1'b1, load_en = 1'b0;
    logic [31:0] instr = '0;
    logic [11:0] vl = 12'd128;
    logic [4:0]  load_idx = '0;
    logic [63:0] load_data = '0;
    logic        in_ready, out_valid, out_undef, out_wr_en;
    logic [4:0]  out_wr_idx;
    logic [63:0] out_result;

    int vectors = 0, fails = 0;
    bit started = 0, done = 0;
    logic [63:0] model [32];
    logic nx_v = 0, nx_u = 0, nx_w = 0, cu_v = 0, cu_u = 0, cu_w = 0;
    logic [4:0]  nx_i = 0, cu_i = 0;
    logic [63:0] nx_r = 0, cu_r = 0;
    string nx_tag = "R1", cu_tag = "R1";

    vl_scaled_adder dut (.*);

    always #5 clk = ~clk;

    // Expected values advance with the design's registers.
    always @(posedge clk) begin
        cu_v <= nx_v; cu_u <= nx_u; cu_w <= nx_w;
        cu_i <= nx_i; cu_r <= nx_r; cu_tag <= nx_tag;
        started <= 1;
    end

    task automatic fail_line(string tag, string what, logic [63:0] act, logic [63:0] exp);
        fails++;
        $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    endtask

    // Compare outputs with the reference on every falling edge.
    always @(negedge clk) if (started && !done) begin
        vectors++;
        if (out_valid !== cu_v) fail_line(cu_tag, "out_valid", 64'(out_valid), 64'(cu_v));
        else if (cu_v) begin
            if (out_undef !== cu_u) fail_line(cu_tag, "out_undef", 64'(out_undef), 64'(cu_u));
            if (out_wr_en !== cu_w) fail_line(cu_tag, "out_wr_en", 64'(out_wr_en), 64'(cu_w));
            if (cu_w && out_wr_idx !== cu_i) fail_line(cu_tag, "out_wr_idx", 64'(out_wr_idx), 64'(cu_i));
            if (cu_w && out_result !== cu_r) fail_line(cu_tag, "out_result", out_result, cu_r);
        end
    end

    task automatic idle(string tag);
        @(negedge clk);
        in_valid = 0; load_en = 0;
        nx_v = 0; nx_u = 0; nx_w = 0; nx_tag = tag;
    endtask

    task automatic load(int idx, logic [63:0] data, bit also_valid, string tag);
        @(negedge clk);
        load_en = 1; load_idx = 5'(idx); load_data = data; in_valid = also_valid;
        nx_v = 0; nx_u = 0; nx_w = 0; nx_tag = tag;
        model[idx] = data;
        #1;
        vectors++;
        if (in_ready !== 1'b0) fail_line("R2", "in_ready during load", 64'(in_ready), 64'd0);
    endtask

    task automatic exec(int rn, int rd, int imm, int vlen, bit fe, bit bad, string tag);
        logic [31:0] w;
        logic [63:0] res;
        bit und;
        w = {11'b00000100011, 5'(rn), 5'b01010, 6'(imm), 5'(rd)};
        if (bad) w[25] = ~w[25];
        @(negedge clk);
        load_en = 0; in_valid = 1; instr = w; vl = 12'(vlen); feat_en = fe;
        res = model[rn] + 64'(longint'(imm) * longint'(vlen / 64));
        und = bad || !fe;
        nx_v = 1; nx_u = und; nx_w = !und; nx_i = 5'(rd); nx_r = res; nx_tag = tag;
        if (!und) model[rd] = res;
        #1;
        vectors++;
        if (in_ready !== 1'b1) fail_line("R2", "in_ready", 64'(in_ready), 64'd1);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL R2 watchdog expired: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        vectors++;
        if (out_valid !== 1'b0) fail_line("R1", "out_valid in reset", 64'(out_valid), 64'd0);
        rst_n = 1;
        exec(5, 6, 0, 128, 1, 0, "R1");         // reset register reads zero
        exec(31, 7, 0, 128, 1, 0, "R1");        // reset stack pointer reads zero
        load(1, 64'h1000, 0, "R9");
        load(2, 64'h0123_4567_89AB_CDEF, 1, "R9");  // in_valid ignored while loading
        load(31, 64'h8000, 0, "R9");
        exec(1, 3, 7, 128, 1, 0, "R6");         // scale 2
        exec(1, 3, 7, 384, 1, 0, "R6");         // scale 6, not a power of two
        exec(2, 4, 7, 2048, 1, 0, "R6");        // scale 32
        exec(1, 8, -32, 2048, 1, 0, "R5");
        exec(1, 9, 31, 640, 1, 0, "R5");
        exec(1, 10, -1, 1152, 1, 0, "R5");
        exec(31, 11, 3, 256, 1, 0, "R7");       // base from stack pointer
        exec(1, 31, 5, 512, 1, 0, "R8");        // write stack pointer
        exec(31, 12, 0, 128, 1, 0, "R8");       // read it back
        exec(12, 12, 1, 128, 1, 0, "R2");       // dependent back-to-back
        exec(12, 12, 1, 1920, 1, 0, "R2");
        idle("R2");
        idle("R2");
        exec(1, 2, 9, 256, 1, 1, "R3");         // mismatched word
        exec(2, 13, 0, 128, 1, 0, "R3");        // X2 unchanged
        exec(1, 2, 9, 256, 0, 0, "R4");         // feature disabled
        exec(2, 13, 0, 128, 1, 0, "R4");        // X2 unchanged
        exec(1, 31, 9, 256, 0, 0, "R4");
        exec(31, 14, 0, 128, 1, 0, "R4");       // SP unchanged
        load(4, 64'hFFFF_FFFF_FFFF_FFF0, 0, "R9");
        exec(4, 15, 31, 2048, 1, 0, "R10");     // wraps past 2^64
        exec(15, 16, -32, 2048, 1, 0, "R10");   // wraps back below zero
        exec(30, 30, -3, 768, 1, 0, "R8");      // register 30 is a plain register
        exec(30, 17, 0, 128, 1, 0, "R7");
        idle("R2");
        idle("R2");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule